// File: doc/BRIEF.md
# Parallel-Port Adapter Unlock Sequencer

This block sits on the host side of a PC-style parallel port. It drives the port lines to wake or release an IDE bridge adapter that sits behind the port. On a start pulse it plays a fixed series of twelve port steps. Seven fixed key bytes go onto the data lines, then a command byte. The control lines then pulse low-high-low, and the data lines return to all ones. Every step is held for a programmable number of clock cycles, because the adapter cannot run at the host clock rate.

Three operations are offered. Attach plays one series with command 0x20. Release plays one series with command 0x30. Probe first sets the control lines to 0xC. It then plays three series with commands 0x30, 0x00 and 0x20. During the last of these it samples the upper status nibble at three points and assembles a 12-bit adapter identifier. At the end of a probe, id_ok reports whether the identifier equals 0xB5F.

The controller is a single state machine with these states:
- IDLE: waiting for start.
- PREP: the probe-only step that sets the control lines to 0xC.
- BYTES: the key bytes and the command byte, using step index 0..7.
- STROBE: the control pulse, using step index 0..2.
- PARK: data lines back to 0xFF.
- DONE: one cycle that ends the operation.

Its transitions are:
- IDLE to PREP on an accepted probe.
- IDLE to BYTES on an accepted attach or release.
- PREP to BYTES when the step expires.
- BYTES to STROBE after index 7.
- STROBE to PARK after index 2.
- PARK to BYTES when a further probe series remains.
- PARK to DONE after the last series.
- DONE to IDLE always.

Top module: `pport_unlock_seq`

## Requirements
- R1: The outputs take their rest values after reset and whenever no operation runs: data_out = 0xFF, ctrl_out = 0x4, busy = 0, done = 0. After reset, id_ok = 0.
- R2: cmd_sel = 0 (attach) produces these data values, in order: 0xFE, 0xAA, 0x55, 0x00, 0xFF, 0x87, 0x78, 0x20. While they are shown, ctrl_out stays 0x4. ctrl_out then steps through 0x4, 0x5, 0x4 while data_out keeps 0x20. A final step shows data_out = 0xFF with ctrl_out = 0x4.
- R3: cmd_sel = 1 (release) produces the same series as attach, except that the command byte is 0x30.
- R4: cmd_sel = 2 (probe) first holds one step with ctrl_out = 0xC and data_out = 0xFF. It then plays three series with command bytes 0x30, 0x00 and 0x20. ctrl_out stays 0xC during the eight data steps of the first series and is 0x4 during the data steps of the later series.
- R5: Every step lasts hold_cycles + 1 clock cycles. The hold value is taken when a start is accepted, and later changes to hold_cycles do not affect a running operation.
- R6: Timing of busy and done:
  - busy is high from the cycle after the accepting edge through the last cycle of the last step.
  - done is high for exactly the one following cycle, with busy low.
  - The block then returns to rest.
- R7: Some start pulses are ignored and leave the outputs unchanged: a start while busy or done is high, and a start with cmd_sel = 3.
- R8: In the third probe series, status_in[7:4] is sampled in the last cycle of three steps:
  - the 0xFF key byte step gives ID bits 11:8;
  - the 0x87 step gives ID bits 7:4;
  - the ctrl_out = 0x5 step gives ID bits 3:0.

  id_ok is 1 exactly when the ID equals 0xB5F. status_in[3:0] is ignored.
- R9: id_ok changes only when a probe ends, and the new value is visible in the done cycle. At all other times id_ok keeps its value, including across attach and release operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Requests an operation |
| cmd_sel | input | 2 | Operation: 0 attach, 1 release, 2 probe, 3 none |
| hold_cycles | input | HOLD_W | Extra cycles each step is held |
| status_in | input | 8 | Port status lines |
| data_out | output | 8 | Port data lines |
| ctrl_out | output | 4 | Port control lines |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| id_ok | output | 1 | Last probe found identifier 0xB5F |

## Verification
An accepted start shows its first step on the outputs in the cycle right after the accepting edge. Each step then stays on the outputs for exactly hold_cycles + 1 cycles. done and the new id_ok follow one cycle after the last step. The bench builds the expected step list arithmetically and compares the port values on every falling edge across the whole operation, so an early, late or missing step is caught at the cycle where it occurs. The bench's model adapter gives each sample point its own status nibble, and a sweep walks each nibble through all sixteen values.

// File: rtl/pport_unlock_pkg.sv
package pport_unlock_pkg;

    localparam int BYTE_W       = 8;
    localparam int CTRL_W       = 4;
    localparam int NIB_W        = 4;
    localparam int ID_NIBS      = 3;
    localparam int ID_W         = NIB_W * ID_NIBS;
    localparam int MAGIC_LEN    = 7;
    localparam int STROBE_LEN   = 3;
    localparam int PROBE_SERIES = 3;
    localparam int IDX_W        = $clog2(MAGIC_LEN + 1);
    localparam int SER_W        = $clog2(PROBE_SERIES + 1);

    localparam logic [ID_W-1:0]   ID_EXPECT    = 12'hB5F;
    localparam logic [BYTE_W-1:0] DATA_REST    = 8'hFF;
    localparam logic [BYTE_W-1:0] CODE_ATTACH  = 8'h20;
    localparam logic [BYTE_W-1:0] CODE_RELEASE = 8'h30;
    localparam logic [BYTE_W-1:0] CODE_BLANK   = 8'h00;
    localparam logic [CTRL_W-1:0] CTRL_REST    = 4'h4;
    localparam logic [CTRL_W-1:0] CTRL_PREP    = 4'hC;
    localparam logic [CTRL_W-1:0] CTRL_STROBE  = 4'h5;

    // step positions used for identifier sampling
    localparam logic [IDX_W-1:0] IDX_SAMPLE_HI  = 3'd4;
    localparam logic [IDX_W-1:0] IDX_SAMPLE_MID = 3'd5;
    localparam logic [IDX_W-1:0] IDX_CMD        = 3'(MAGIC_LEN);
    localparam logic [IDX_W-1:0] IDX_STRB_HIGH  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_STRB_LAST  = 3'(STROBE_LEN - 1);

    typedef enum logic [1:0] {
        OP_ATTACH  = 2'd0,
        OP_RELEASE = 2'd1,
        OP_PROBE   = 2'd2,
        OP_NONE    = 2'd3
    } op_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PREP,
        PH_BYTES,
        PH_STROBE,
        PH_PARK,
        PH_DONE
    } phase_t;

    function automatic logic [BYTE_W-1:0] key_byte(input logic [IDX_W-1:0] i);
        logic [BYTE_W-1:0] v;
        unique case (i)
            3'd0:    v = 8'hFE;
            3'd1:    v = 8'hAA;
            3'd2:    v = 8'h55;
            3'd3:    v = 8'h00;
            3'd4:    v = 8'hFF;
            3'd5:    v = 8'h87;
            3'd6:    v = 8'h78;
            default: v = DATA_REST;
        endcase
        return v;
    endfunction

    function automatic logic [BYTE_W-1:0] cmd_code(input op_t op, input logic [SER_W-1:0] ser);
        logic [BYTE_W-1:0] v;
        unique case (op)
            OP_ATTACH:  v = CODE_ATTACH;
            OP_RELEASE: v = CODE_RELEASE;
            OP_PROBE:   v = (ser == 2'd0) ? CODE_RELEASE :
                            (ser == 2'd1) ? CODE_BLANK : CODE_ATTACH;
            default:    v = CODE_ATTACH;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pport_step_timer.sv
module pport_step_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] hold_val,
    output logic              expire
);

    logic [HOLD_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= hold_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);

    // R5: the remaining count never exceeds the latched hold
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= hold_val);

endmodule

// File: rtl/pport_id_capture.sv
module pport_id_capture
    import pport_unlock_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_NIBS-1:0] cap_en,
    input  logic [NIB_W-1:0]   status_nib,
    input  logic               commit,
    output logic               id_ok
);

    logic [NIB_W-1:0] nib_q [ID_NIBS];
    logic [ID_W-1:0]  id_word;

    for (genvar g = 0; g < ID_NIBS; g++) begin : g_nib
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nib_q[g] <= '0;
            end else if (cap_en[g]) begin
                nib_q[g] <= status_nib;
            end
        end
    end

    always_comb begin
        id_word = '0;
        for (int k = 0; k < ID_NIBS; k++) begin
            id_word[k*NIB_W +: NIB_W] = nib_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_ok <= 1'b0;
        end else if (commit) begin
            id_ok <= (id_word == ID_EXPECT);
        end
    end

    // R8: at most one sample point per cycle
    p_cap_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cap_en));

    // R9: verdict only moves on a probe commit
    p_idok_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(id_ok));

endmodule

// File: rtl/pport_unlock_seq.sv
module pport_unlock_seq
    import pport_unlock_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cmd_sel,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic [7:0]        status_in,
    output logic [7:0]        data_out,
    output logic [3:0]        ctrl_out,
    output logic              busy,
    output logic              done,
    output logic              id_ok
);

    phase_t            phase_q, phase_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [SER_W-1:0]  ser_q, ser_d;
    op_t               op_q, op_d;
    logic [HOLD_W-1:0] hold_q, hold_d;

    logic              expire;
    logic              step_load;
    logic              accept;
    logic              last_series;
    logic              probe_final;
    logic [ID_NIBS-1:0] cap_en;
    logic              commit;
    logic [BYTE_W-1:0] cur_cmd;

    assign accept      = (phase_q == PH_IDLE) && start && (op_t'(cmd_sel) != OP_NONE);
    assign last_series = (op_q != OP_PROBE) || (ser_q == SER_W'(PROBE_SERIES - 1));
    assign probe_final = (op_q == OP_PROBE) && (ser_q == SER_W'(PROBE_SERIES - 1));
    assign cur_cmd     = cmd_code(op_q, ser_q);

    // next-state process
    always_comb begin
        phase_d   = phase_q;
        idx_d     = idx_q;
        ser_d     = ser_q;
        op_d      = op_q;
        hold_d    = hold_q;
        step_load = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    op_d      = op_t'(cmd_sel);
                    hold_d    = hold_cycles;
                    idx_d     = '0;
                    ser_d     = '0;
                    step_load = 1'b1;
                    phase_d   = (op_t'(cmd_sel) == OP_PROBE) ? PH_PREP : PH_BYTES;
                end
            end
            PH_PREP: begin
                if (expire) begin
                    phase_d   = PH_BYTES;
                    idx_d     = '0;
                    step_load = 1'b1;
                end
            end
            PH_BYTES: begin
                if (expire) begin
                    step_load = 1'b1;
                    if (idx_q == IDX_CMD) begin
                        phase_d = PH_STROBE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            PH_STROBE: begin
                if (expire) begin
                    step_load = 1'b1;
                    if (idx_q == IDX_STRB_LAST) begin
                        phase_d = PH_PARK;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            PH_PARK: begin
                if (expire) begin
                    if (last_series) begin
                        phase_d = PH_DONE;
                    end else begin
                        phase_d   = PH_BYTES;
                        ser_d     = ser_q + 1'b1;
                        idx_d     = '0;
                        step_load = 1'b1;
                    end
                end
            end
            PH_DONE: begin
                phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            ser_q   <= '0;
            op_q    <= OP_ATTACH;
            hold_q  <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
            ser_q   <= ser_d;
            op_q    <= op_d;
            hold_q  <= hold_d;
        end
    end

    // output process
    always_comb begin
        data_out = DATA_REST;
        ctrl_out = CTRL_REST;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (phase_q)
            PH_IDLE: ;
            PH_PREP: begin
                ctrl_out = CTRL_PREP;
                busy     = 1'b1;
            end
            PH_BYTES: begin
                data_out = (idx_q == IDX_CMD) ? cur_cmd : key_byte(idx_q);
                ctrl_out = (op_q == OP_PROBE && ser_q == '0) ? CTRL_PREP : CTRL_REST;
                busy     = 1'b1;
            end
            PH_STROBE: begin
                data_out = cur_cmd;
                ctrl_out = (idx_q == IDX_STRB_HIGH) ? CTRL_STROBE : CTRL_REST;
                busy     = 1'b1;
            end
            PH_PARK: begin
                busy = 1'b1;
            end
            PH_DONE: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // identifier sample points, last cycle of each step
    assign cap_en[2] = probe_final && expire && (phase_q == PH_BYTES) && (idx_q == IDX_SAMPLE_HI);
    assign cap_en[1] = probe_final && expire && (phase_q == PH_BYTES) && (idx_q == IDX_SAMPLE_MID);
    assign cap_en[0] = probe_final && expire && (phase_q == PH_STROBE) && (idx_q == IDX_STRB_HIGH);
    assign commit    = probe_final && expire && (phase_q == PH_PARK);

    pport_step_timer #(.HOLD_W(HOLD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (step_load),
        .hold_val (hold_d),
        .expire   (expire)
    );

    pport_id_capture u_idcap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .status_nib (status_in[7:4]),
        .commit     (commit),
        .id_ok      (id_ok)
    );

    // R6: busy and done never overlap
    p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R6: done is a single-cycle pulse followed by rest
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R5: outputs hold while the step timer runs
    p_step_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !expire) |=> ($stable(data_out) && $stable(ctrl_out)));

    // R1: rest values whenever not busy
    p_rest_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (data_out == DATA_REST && ctrl_out == CTRL_REST));

    // R7: a valid start at rest begins an operation
    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start && cmd_sel != 2'd3) |=> busy);

endmodule

// File: tb/pport_unlock_seq_bench.sv
module pport_unlock_seq_bench;

    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    cmd_sel = 2'd0;
    logic [HW-1:0] hold_cycles = '0;
    logic [7:0]    status_in;
    logic [7:0]    data_out;
    logic [3:0]    ctrl_out;
    logic          busy, done, id_ok;

    logic [3:0] m_hi = 4'hB, m_mid = 4'h5, m_lo = 4'hF;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic exp_idok = 1'b0;

    logic [7:0] exp_d [0:39];
    logic [3:0] exp_c [0:39];
    int         n_steps;

    always #4 clk = ~clk;

    // model adapter: distinct nibble per sample point, junk elsewhere
    always_comb begin
        if (data_out == 8'hFF && ctrl_out == 4'h4) status_in = {m_hi, 4'h6};
        else if (data_out == 8'h87)                status_in = {m_mid, 4'h9};
        else if (ctrl_out == 4'h5)                 status_in = {m_lo, 4'h2};
        else                                       status_in = 8'h3C;
    end

    pport_unlock_seq #(.HOLD_W(HW)) u_pport_unlock_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_sel(cmd_sel),
        .hold_cycles(hold_cycles), .status_in(status_in),
        .data_out(data_out), .ctrl_out(ctrl_out),
        .busy(busy), .done(done), .id_ok(id_ok)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [3:0] c);
        exp_d[n_steps] = d;
        exp_c[n_steps] = c;
        n_steps = n_steps + 1;
    endtask

    task automatic build(input int op);
        int ns;
        logic [7:0] keys [0:6];
        keys = '{8'hFE, 8'hAA, 8'h55, 8'h00, 8'hFF, 8'h87, 8'h78};
        n_steps = 0;
        ns = (op == 2) ? 3 : 1;
        if (op == 2) push(8'hFF, 4'hC);
        for (int s = 0; s < ns; s++) begin
            logic [7:0] cb;
            logic [3:0] pc;
            if (op == 0) cb = 8'h20;
            else if (op == 1) cb = 8'h30;
            else cb = (s == 0) ? 8'h30 : (s == 1) ? 8'h00 : 8'h20;
            pc = (op == 2 && s == 0) ? 4'hC : 4'h4;
            for (int k = 0; k < 7; k++) push(keys[k], pc);
            push(cb, pc);
            push(cb, 4'h4);
            push(cb, 4'h5);
            push(cb, 4'h4);
            push(8'hFF, 4'h4);
        end
    endtask

    // run one operation and compare every cycle
    task automatic run_op(input int op, input int hold, input bit disturb, input string req);
        int trace_bad = 0;
        int busy_bad  = 0;
        int first_bad = -1;
        build(op);
        @(negedge clk);
        cmd_sel = 2'(op);
        hold_cycles = HW'(hold);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int s = 0; s < n_steps; s++) begin
            for (int c = 0; c <= hold; c++) begin
                if (s != 0 || c != 0) @(negedge clk);
                if (disturb && s == 3 && c == 0) begin
                    start = 1'b1;
                    cmd_sel = (op == 2) ? 2'd0 : 2'd2;
                    hold_cycles = HW'(hold + 3);
                end
                if (disturb && s == 4 && c == 0) start = 1'b0;
                if (data_out !== exp_d[s] || ctrl_out !== exp_c[s]) begin
                    trace_bad = trace_bad + 1;
                    if (first_bad < 0) first_bad = s;
                end
                if (busy !== 1'b1 || done !== 1'b0) busy_bad = busy_bad + 1;
            end
        end
        check(trace_bad == 0, req, first_bad, -1);
        check(busy_bad == 0, "R6 busy span", busy_bad, 0);
        @(negedge clk);
        check(done === 1'b1 && busy === 1'b0, "R6 done pulse", {busy, done}, 1);
        if (op == 2) exp_idok = ({m_hi, m_mid, m_lo} == 12'hB5F);
        check(id_ok === exp_idok, "R8 R9 id_ok at done", id_ok, exp_idok);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0 && data_out === 8'hFF && ctrl_out === 4'h4,
              "R6 R1 rest after done", {busy, done, data_out, ctrl_out}, 12'h0FF4 & 16'h0FF4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(data_out === 8'hFF, "R1 data", data_out, 8'hFF);
        check(ctrl_out === 4'h4, "R1 ctrl", ctrl_out, 4'h4);
        check(busy === 1'b0 && done === 1'b0 && id_ok === 1'b0, "R1 flags",
              {busy, done, id_ok}, 0);

        // R7 cmd_sel 3 ignored
        @(negedge clk);
        cmd_sel = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && data_out === 8'hFF && ctrl_out === 4'h4,
              "R7 none op ignored", {busy, done, data_out}, 12'h0FF);

        // R2 R3 R5 hold sweep for attach and release
        for (int h = 0; h < 4; h++) begin
            run_op(0, h, 1'b0, "R2 R5 attach trace");
            run_op(1, h, 1'b0, "R3 R5 release trace");
        end

        // R4 probe with matching adapter
        m_hi = 4'hB; m_mid = 4'h5; m_lo = 4'hF;
        run_op(2, 1, 1'b0, "R4 probe trace");
        // R9 attach keeps id_ok
        run_op(0, 0, 1'b0, "R2 attach after probe");
        check(id_ok === 1'b1, "R9 id_ok kept", id_ok, 1);

        // R8 sweep each nibble through all values
        for (int pos = 0; pos < 3; pos++) begin
            for (int v = 0; v < 16; v++) begin
                m_hi = 4'hB; m_mid = 4'h5; m_lo = 4'hF;
                if (pos == 0) m_hi = 4'(v);
                else if (pos == 1) m_mid = 4'(v);
                else m_lo = 4'(v);
                run_op(2, 0, 1'b0, "R4 R8 probe sweep");
            end
        end

        // R7 R5 start and hold changes while busy are ignored
        run_op(0, 1, 1'b1, "R7 R5 disturbed attach");
        run_op(2, 2, 1'b1, "R7 R5 disturbed probe");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule